// File: doc/BRIEF.md
# Event Status Register Group

This block collects one-shot status events into an 8-bit latched event register and reduces them, through an 8-bit enable mask, to a single summary bit that feeds a higher-level status byte. Each event input is a single-cycle pulse. Once latched, an event bit stays set until software reads the event register or a clear-status pulse arrives. The bit positions are fixed by their meaning. Bit 0 is operation complete. Bits 2 to 5 are the four error classes: query, device-dependent, execution and command. Bit 7 is power-on, which the block raises by itself once after each reset.

Software reaches the block over a small register port with one-cycle read latency. Address 0 is the event register. A read of it returns the latched events and empties the register in the same access, which also drops the summary condition. Address 1 is the enable mask and can be both read and written. A power-on-clear setting decides what happens to the mask across a reset. When the setting is high the mask is forced to zero. When it is low the mask keeps the value it held before the reset.

Top module: `evt_status_group`

## Requirements
- R1: While reset is asserted, `summary` is 0 and `bus_rdata` is 0.
- R2: After reset is released, event bit 7 (power-on) becomes set exactly once. Once it has been read away it does not return until the next reset.
- R3: A one-cycle pulse on `evt_in[i]` sets event bit i. The bit stays set for any number of cycles until a read of address 0 or a `clr_stat` pulse.
- R4: A read (`bus_req`=1, `bus_wr`=0) of address 0 returns the event register on `bus_rdata` in the cycle after the request and clears the register in the same access. `bus_rdata` is 0 in any cycle not following a read.
- R5: An event pulse in the same cycle as a read of address 0 is not lost. It is absent from that read's data and present in the register afterwards.
- R6: `summary` is 1 exactly when some event bit is set whose mask bit is also set. A mask write changes `summary` in the cycle after the write.
- R7: Address 1 writes and reads the enable mask, and reading it does not alter it. Mask 0x3C (bits 2..5) passes only the error events. Mask 0x81 (bits 7 and 0) passes only power-on and operation complete.
- R8: A `clr_stat` pulse clears the event register and leaves the mask unchanged.
- R9: If `pwr_on_clr` is 1 during reset, the mask reads 0 after reset. If it is 0, the mask keeps its value from before the reset.
- R10: A write to address 0 does not change the event register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_on_clr | input | 1 | Power-on-clear setting; 1 zeroes the mask during reset |
| evt_in | input | 8 | Single-cycle event pulses, one per event bit |
| clr_stat | input | 1 | Clear-status pulse: empties the event register |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = event register, 1 = enable mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read request, else 0 |
| summary | output | 1 | OR of enabled, set event bits |

## Verification
The hardest case to reach from the ports is a pulse that lands in the same cycle as the destructive read. The bench first latches one known event. It then drives a different event pulse together with the read request on the same edge, and checks that the read returns only the first event and that a second read returns only the second. The other hard case is mask retention across reset, because it is visible only through a reset. The bench loads a distinctive mask, cycles reset with the power-on-clear setting low and then high, and reads the mask back after each reset.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EVS_W       = 8;
  localparam int EVS_ADDR_W  = 1;
  localparam int PON_BIT     = 7;
  localparam int OPC_BIT     = 0;
  localparam logic [EVS_ADDR_W-1:0] ADDR_EVENT = 1'b0;
  localparam logic [EVS_ADDR_W-1:0] ADDR_MASK  = 1'b1;
endpackage

// File: rtl/evs_rst_sync.sv
module evs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evs_event_bank.sv
module evs_event_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] evt_d;
  logic [W-1:0] evt_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // a fresh pulse wins over a clear in the same cycle
    always_comb begin
      evt_en[i] = set_i[i] | clr_i;
      evt_d[i]  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         evt_q[i] <= 1'b0;
      else if (evt_en[i]) evt_q[i] <= evt_d[i];
    end
  end
endmodule

// File: rtl/evs_mask_reg.sv
module evs_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         pwr_on_clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  logic         mask_en;
  logic [W-1:0] mask_d;

  // retention register: no asynchronous reset, cleared under reset only by policy
  always_comb begin
    mask_en = 1'b0;
    mask_d  = wr_data;
    if (!rst_sync_n) begin
      mask_en = pwr_on_clr;
      mask_d  = '0;
    end else if (wr_en) begin
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/evt_status_group.sv
module evt_status_group
  import evs_pkg::*;
#(
  parameter int W           = EVS_W,
  parameter int ADDR_W      = EVS_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_clr,
  input  logic [W-1:0]      evt_in,
  input  logic              clr_stat,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              summary
);
  logic         rst_sync_n;
  logic         pon_done;
  logic         pon_set;
  logic [W-1:0] set_vec;
  logic         rd_event;
  logic         rd_mask;
  logic         wr_mask;
  logic         evt_clr;
  logic [W-1:0] evt_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] rdata_d;

  evs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // one-shot power-on event on the first cycle out of reset
  always_comb pon_set = ~pon_done;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pon_done <= 1'b0;
    else if (pon_set) pon_done <= 1'b1;
  end

  always_comb begin
    rd_event = bus_req & ~bus_wr & (bus_addr == ADDR_EVENT);
    rd_mask  = bus_req & ~bus_wr & (bus_addr == ADDR_MASK);
    wr_mask  = bus_req &  bus_wr & (bus_addr == ADDR_MASK);
    evt_clr  = rd_event | clr_stat;
    set_vec  = evt_in;
    set_vec[PON_BIT] = evt_in[PON_BIT] | pon_set;
  end

  evs_event_bank #(.W(W)) u_events (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (set_vec),
    .clr_i (evt_clr),
    .evt_q (evt_q)
  );

  evs_mask_reg #(.W(W)) u_mask (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .pwr_on_clr (pwr_on_clr),
    .wr_en      (wr_mask),
    .wr_data    (bus_wdata),
    .mask_q     (mask_q)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_event)     rdata_d = evt_q;
    else if (rd_mask) rdata_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else             bus_rdata <= rdata_d;
  end

  always_comb summary = |(evt_q & mask_q);
endmodule

// File: rtl/evs_status_chk.sv
module evs_status_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [W-1:0]      evt_in,
  input logic              clr_stat,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_rdata,
  input logic              summary,
  input logic [W-1:0]      evt_q,
  input logic [W-1:0]      mask_q,
  input logic              pon_done
);
  logic rd_ev;
  logic any_rd;
  logic mask_wr;
  assign rd_ev   = bus_req && !bus_wr && (bus_addr == '0);
  assign any_rd  = bus_req && !bus_wr;
  assign mask_wr = bus_req && bus_wr && (bus_addr != '0);

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!summary && bus_rdata == '0));

  p_pon_sticky_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pon_done |=> pon_done);

  p_pulse_latches_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_in != '0) |=> ((evt_q & $past(evt_in)) == $past(evt_in)));

  p_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_ev && evt_in == '0) |=> (evt_q == '0 && !summary));

  p_idle_rdata_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_rd |=> (bus_rdata == '0));

  p_mask_holds_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mask_wr |=> $stable(mask_q));

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_stat && evt_in == '0) |=> !summary);
endmodule

bind evt_status_group evs_status_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .evt_in     (evt_in),
  .clr_stat   (clr_stat),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .summary    (summary),
  .evt_q      (evt_q),
  .mask_q     (mask_q),
  .pon_done   (pon_done)
);

// File: tb/evt_status_group_tb.sv
module evt_status_group_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_on_clr;
  logic [7:0] evt_in;
  logic       clr_stat;
  logic       bus_req;
  logic       bus_wr;
  logic [0:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       summary;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  evt_status_group u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_clr(pwr_on_clr), .evt_in(evt_in),
    .clr_stat(clr_stat), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .summary(summary)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_in = '0; clr_stat = 0; bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic poc);
    @(negedge clk);
    idle();
    rst_n = 0; pwr_on_clr = poc;
    cyc(4);
    rst_n = 1;
    cyc(5);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    cyc(1);
    d = bus_rdata;
    idle();
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    cyc(1);
    idle();
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_in = v;
    cyc(1);
    idle();
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    @(negedge clk);
    idle(); rst_n = 0; pwr_on_clr = 1;
    cyc(4);
    chk("R1 summary in reset", {7'd0, summary}, 8'h00);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1;
    cyc(5);
    bus_read(1'b1, d);
    chk("R9 mask zero after reset with power-on-clear", d, 8'h00);
  endtask

  task automatic t_power_on();
    logic [7:0] d;
    bus_read(1'b0, d);
    chk("R2 power-on event after reset", d, 8'h80);
    cyc(1);
    chk("R4 rdata back to 0 after read", bus_rdata, 8'h00);
    cyc(6);
    bus_read(1'b0, d);
    chk("R2 power-on does not recur", d, 8'h00);
  endtask

  task automatic t_mask_rw();
    logic [7:0] d;
    bus_write(1'b1, 8'h81);
    bus_read(1'b1, d);
    chk("R7 mask readback", d, 8'h81);
    bus_read(1'b1, d);
    chk("R7 mask read is non-destructive", d, 8'h81);
    chk("R6 no events gives no summary", {7'd0, summary}, 8'h00);
    pulse(8'h01);
    chk("R7 op-complete passes mask 0x81", {7'd0, summary}, 8'h01);
    bus_read(1'b0, d);
    chk("R4 read returns op-complete", d, 8'h01);
    chk("R4 summary dropped after read", {7'd0, summary}, 8'h00);
  endtask

  task automatic t_error_mask();
    logic [7:0] d;
    pulse(8'h08);
    chk("R7 error bit blocked by mask 0x81", {7'd0, summary}, 8'h00);
    bus_req = 1; bus_wr = 1; bus_addr = 1'b1; bus_wdata = 8'h3C;
    chk("R6 summary before mask edge", {7'd0, summary}, 8'h00);
    cyc(1);
    idle();
    chk("R6 summary the cycle after mask write", {7'd0, summary}, 8'h01);
    bus_read(1'b0, d);
    chk("R3 error bit 3 latched", d, 8'h08);
    chk("R4 summary cleared by read", {7'd0, summary}, 8'h00);
  endtask

  task automatic t_read_collision();
    logic [7:0] d;
    pulse(8'h04);
    bus_req = 1; bus_wr = 0; bus_addr = 1'b0; evt_in = 8'h10;
    cyc(1);
    d = bus_rdata;
    idle();
    chk("R5 colliding read sees only older event", d, 8'h04);
    chk("R5 summary kept by colliding pulse", {7'd0, summary}, 8'h01);
    bus_read(1'b0, d);
    chk("R5 colliding pulse kept", d, 8'h10);
  endtask

  task automatic t_clear_status();
    logic [7:0] d;
    pulse(8'h20);
    chk("R3 bit 5 raises summary", {7'd0, summary}, 8'h01);
    clr_stat = 1;
    cyc(1);
    idle();
    chk("R8 clear drops summary", {7'd0, summary}, 8'h00);
    bus_read(1'b0, d);
    chk("R8 events empty after clear", d, 8'h00);
    bus_read(1'b1, d);
    chk("R8 mask unchanged by clear", d, 8'h3C);
  endtask

  task automatic t_write_event_ignored();
    logic [7:0] d;
    pulse(8'h04);
    bus_write(1'b0, 8'h00);
    bus_read(1'b0, d);
    chk("R10 write of 0 to event reg ignored", d, 8'h04);
    bus_write(1'b0, 8'hFF);
    bus_read(1'b0, d);
    chk("R10 write of FF to event reg ignored", d, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    pulse(8'h40);
    cyc(12);
    bus_read(1'b0, d);
    chk("R3 bit 6 held over many cycles", d, 8'h40);
  endtask

  task automatic t_retention();
    logic [7:0] d;
    bus_write(1'b1, 8'h55);
    do_reset(1'b0);
    bus_read(1'b1, d);
    chk("R9 mask kept without power-on-clear", d, 8'h55);
    bus_read(1'b0, d);
    chk("R2 power-on event after second reset", d, 8'h80);
    do_reset(1'b1);
    bus_read(1'b1, d);
    chk("R9 mask zeroed with power-on-clear", d, 8'h00);
  endtask

  initial begin
    idle();
    rst_n = 0;
    pwr_on_clr = 1;
    t_reset_state();
    t_power_on();
    t_mask_rw();
    t_error_mask();
    t_read_collision();
    t_clear_status();
    t_write_event_ignored();
    t_hold();
    t_retention();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule